// File: doc/BRIEF.md
# Staggered Four-Phase Switch Sequencer

This block turns one commanded on-time and one commanded period, both counted in clock ticks, into four switch-enable outputs for high-side power switches. The channels are offset in phase so that the switches do not all turn on together and the total load current changes in small steps. Two extra loads hang on the switches of channels 2 and 4, so four phases serve all loads.

A start pulse begins a run. The run opens with a five-step ramp, one step per commanded period. In the first step the channels are spaced by a short fixed delay, so all four turn on once inside the first period. The spacing then moves in equal steps until, from the fifth step on, each channel turns on a fixed gap after the one before it has turned off. The spacing is cut back whenever the last channel would otherwise end past the period. Each channel also drives a blanking flag for a fixed time after every edge of its enable, so that fault monitors can ignore the switching slope. A stop pulse turns all switches off at once.

Top module: `phase_pwm_seq`

## Requirements
- R1: After reset and until the first start pulse, every enable and every blanking output is low.
- R2: While running, with tick count t inside the current period (t = 0 at the period's first cycle), channel k (k = 0..3) is enabled exactly when k*S <= t < k*S + ON, where S is the spacing in force and ON is the captured on-time.
- R3: A start pulse (without stop) restarts the sequence at step 1 with t = 0 in the next cycle, and step 1 uses spacing DEL_TICKS.
- R4: The step advances by one at each period end and stays at step 5; in step j (j = 1..5) the spacing is DEL_TICKS + (ON + GAP_TICKS - DEL_TICKS)*(j-1)/4, the division truncating toward zero.
- R5: From step 5 on, each channel turns on exactly GAP_TICKS ticks after the previous channel turns off, unless R6 limits the spacing.
- R6: The spacing is limited to (PERIOD - ON)/3 rounded down (0 when PERIOD < ON), so the last channel ends within the period.
- R7: A stop pulse forces all enables low in the next cycle and holds them low until the next start pulse; stop has priority over a start pulse in the same cycle, and the following start begins at step 1.
- R8: Each channel's blanking output is high in the cycle its enable changes and for SUP_TICKS cycles in total, re-armed by every further edge.
- R9: On-time and period are captured at a start pulse and again at each period end; changes between those instants have no effect on the enables.
- R10: A start pulse during a run restarts the sequence at step 1 from t = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | One-cycle pulse that starts or restarts a run |
| stop_i | input | 1 | One-cycle pulse that ends a run |
| on_ticks_i | input | CNT_W | Commanded on-time per channel in ticks |
| period_ticks_i | input | CNT_W | Commanded period in ticks (at least 1) |
| en_o | output | NUM_CH | Switch enables, bit k for channel k |
| blank_o | output | NUM_CH | Failure-blanking flags, bit k for channel k |

## Verification
The enables are decoded from registered state, so a start or stop pulse sampled at one edge shows on the enables right after that edge, and a new period's spacing takes effect in the first cycle after the period-end edge. Blanking rises in the same cycle as the enable edge and stays up SUP_TICKS cycles. The bench steps a behavioural model at each rising edge and compares both output vectors at the falling edge, where those registered results have settled, and drives stimulus only at falling edges.

// File: rtl/phase_pwm_pkg.sv
package phase_pwm_pkg;
  localparam int unsigned DEF_STEPS = 5;
  localparam int unsigned DEF_CH    = 4;
endpackage

// File: rtl/phase_timer.sv
module phase_timer #(
  parameter int unsigned CNT_W     = 20,
  parameter int unsigned NUM_CH    = 4,
  parameter int unsigned DEL_TICKS = 2500,
  parameter int unsigned GAP_TICKS = 150,
  parameter int unsigned SEQ_STEPS = 5,
  localparam int unsigned STEP_W   = $clog2(SEQ_STEPS)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic              stop_i,
  input  logic [CNT_W-1:0]  on_ticks_i,
  input  logic [CNT_W-1:0]  period_ticks_i,
  output logic              active_o,
  output logic [CNT_W-1:0]  tick_o,
  output logic [STEP_W-1:0] step_o,
  output logic [CNT_W-1:0]  space_o,
  output logic [CNT_W-1:0]  on_o,
  output logic [CNT_W-1:0]  per_o
);
  localparam logic [STEP_W-1:0] LAST_STEP = STEP_W'(SEQ_STEPS - 1);

  function automatic logic [CNT_W-1:0] calc_space(input logic [STEP_W-1:0] s,
                                                   input logic [CNT_W-1:0] on_t,
                                                   input logic [CNT_W-1:0] per_t);
    int tgt, diff, sp, lim;
    tgt  = int'(on_t) + int'(GAP_TICKS);
    diff = tgt - int'(DEL_TICKS);
    sp   = int'(DEL_TICKS) + (diff * int'(s)) / int'(SEQ_STEPS - 1);
    if (per_t >= on_t) lim = int'(per_t - on_t) / int'(NUM_CH - 1);
    else               lim = 0;
    if (sp > lim) sp = lim;
    return CNT_W'(sp);
  endfunction

  logic              active_q;
  logic [CNT_W-1:0]  tick_q, on_q, per_q, space_q;
  logic [STEP_W-1:0] step_q, step_nx;
  logic              wrap;

  assign wrap    = ({1'b0, tick_q} + (CNT_W+1)'(1)) >= {1'b0, per_q};
  assign step_nx = (step_q == LAST_STEP) ? step_q : step_q + STEP_W'(1);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      active_q <= 1'b0;
      tick_q   <= '0;
      step_q   <= '0;
      on_q     <= '0;
      per_q    <= '0;
      space_q  <= '0;
    end else if (stop_i) begin
      active_q <= 1'b0;
      tick_q   <= '0;
      step_q   <= '0;
    end else if (start_i) begin
      active_q <= 1'b1;
      tick_q   <= '0;
      step_q   <= '0;
      on_q     <= on_ticks_i;
      per_q    <= period_ticks_i;
      space_q  <= calc_space('0, on_ticks_i, period_ticks_i);
    end else if (active_q) begin
      if (wrap) begin
        tick_q  <= '0;
        step_q  <= step_nx;
        on_q    <= on_ticks_i;
        per_q   <= period_ticks_i;
        space_q <= calc_space(step_nx, on_ticks_i, period_ticks_i);
      end else begin
        tick_q <= tick_q + CNT_W'(1);
      end
    end
  end

  assign active_o = active_q;
  assign tick_o   = tick_q;
  assign step_o   = step_q;
  assign space_o  = space_q;
  assign on_o     = on_q;
  assign per_o    = per_q;
endmodule

// File: rtl/chan_window.sv
module chan_window #(
  parameter int unsigned CNT_W = 20,
  parameter int unsigned IDX   = 0,
  localparam int unsigned EW   = CNT_W + 3
) (
  input  logic             active_i,
  input  logic [CNT_W-1:0] tick_i,
  input  logic [CNT_W-1:0] space_i,
  input  logic [CNT_W-1:0] on_i,
  output logic             en_o
);
  logic [EW-1:0] base, stop_at, t_ext;

  always_comb begin
    base    = EW'(space_i) * EW'(IDX);
    stop_at = base + EW'(on_i);
    t_ext   = EW'(tick_i);
    en_o    = active_i && (t_ext >= base) && (t_ext < stop_at);
  end
endmodule

// File: rtl/blank_timer.sv
module blank_timer #(
  parameter int unsigned SUP_TICKS = 700,
  localparam int unsigned BW       = $clog2(SUP_TICKS + 1)
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic en_i,
  output logic blank_o
);
  logic          en_d;
  logic          edge_w;
  logic [BW-1:0] cnt_q;

  assign edge_w = en_i ^ en_d;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_d  <= 1'b0;
      cnt_q <= '0;
    end else begin
      en_d <= en_i;
      if (edge_w)          cnt_q <= BW'(SUP_TICKS - 1);
      else if (cnt_q != 0) cnt_q <= cnt_q - BW'(1);
    end
  end

  // edge cycle itself plus SUP_TICKS-1 counted cycles
  assign blank_o = edge_w || (cnt_q != '0);
endmodule

// File: rtl/phase_pwm_seq.sv
module phase_pwm_seq
  import phase_pwm_pkg::*;
#(
  parameter int unsigned NUM_CH    = DEF_CH,
  parameter int unsigned CNT_W     = 20,
  parameter int unsigned DEL_TICKS = 2500,
  parameter int unsigned GAP_TICKS = 150,
  parameter int unsigned SUP_TICKS = 700,
  parameter int unsigned SEQ_STEPS = DEF_STEPS,
  localparam int unsigned STEP_W   = $clog2(SEQ_STEPS)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic              stop_i,
  input  logic [CNT_W-1:0]  on_ticks_i,
  input  logic [CNT_W-1:0]  period_ticks_i,
  output logic [NUM_CH-1:0] en_o,
  output logic [NUM_CH-1:0] blank_o
);
  logic              active;
  logic [CNT_W-1:0]  tick, space, on_q, per_q;
  logic [STEP_W-1:0] step;

  phase_timer #(
    .CNT_W(CNT_W), .NUM_CH(NUM_CH), .DEL_TICKS(DEL_TICKS),
    .GAP_TICKS(GAP_TICKS), .SEQ_STEPS(SEQ_STEPS)
  ) u_timer (
    .clk_i, .rst_ni, .start_i, .stop_i,
    .on_ticks_i, .period_ticks_i,
    .active_o(active), .tick_o(tick), .step_o(step),
    .space_o(space), .on_o(on_q), .per_o(per_q)
  );

  for (genvar k = 0; k < NUM_CH; k++) begin : g_ch
    chan_window #(.CNT_W(CNT_W), .IDX(k)) u_win (
      .active_i(active), .tick_i(tick), .space_i(space), .on_i(on_q),
      .en_o(en_o[k])
    );
    blank_timer #(.SUP_TICKS(SUP_TICKS)) u_blank (
      .clk_i, .rst_ni, .en_i(en_o[k]), .blank_o(blank_o[k])
    );
  end
endmodule

// File: rtl/phase_pwm_seq_chk.sv
module phase_pwm_seq_chk #(
  parameter int unsigned NUM_CH    = 4,
  parameter int unsigned CNT_W     = 20,
  parameter int unsigned SEQ_STEPS = 5,
  localparam int unsigned STEP_W   = $clog2(SEQ_STEPS)
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              start_i,
  input logic              stop_i,
  input logic [NUM_CH-1:0] en_o,
  input logic [NUM_CH-1:0] blank_o,
  input logic              active,
  input logic [STEP_W-1:0] step,
  input logic [CNT_W-1:0]  space,
  input logic [CNT_W-1:0]  on_q,
  input logic [CNT_W-1:0]  per_q
);
  logic [CNT_W+3:0] last_end;
  assign last_end = (CNT_W+4)'(space) * (CNT_W+4)'(NUM_CH - 1) + (CNT_W+4)'(on_q);

  // R7
  stop_off_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stop_i |=> (en_o == '0));

  // R8
  blank_edge_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |-> (((en_o ^ $past(en_o)) & ~blank_o) == '0));

  // R4
  step_move_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (step != $past(step)) |-> ((step == $past(step) + STEP_W'(1)) || (step == '0)));

  // R4
  step_cap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    step <= STEP_W'(SEQ_STEPS - 1));

  // R3
  start_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i && !stop_i) |=> (active && step == '0));

  // R6
  clamp_fit_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (active && per_q >= on_q) |-> (last_end <= (CNT_W+4)'(per_q)));

  // R1
  idle_off_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !active |-> (en_o == '0));
endmodule

bind phase_pwm_seq phase_pwm_seq_chk #(
  .NUM_CH(NUM_CH), .CNT_W(CNT_W), .SEQ_STEPS(SEQ_STEPS)
) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .start_i(start_i), .stop_i(stop_i),
  .en_o(en_o), .blank_o(blank_o), .active(active), .step(step),
  .space(space), .on_q(on_q), .per_q(per_q)
);

// File: tb/phase_pwm_seq_test.sv
module phase_pwm_seq_test;
  localparam int NCH = 4;
  localparam int CW  = 16;
  localparam int DEL = 20;
  localparam int GAP = 3;
  localparam int SUP = 5;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          start = 1'b0, stop = 1'b0;
  logic [CW-1:0] on_t = '0, per_t = '0;
  logic [NCH-1:0] en, blank;

  int checks = 0, errors = 0;
  bit done = 0;
  string req = "R1";

  always #5 clk = ~clk;

  phase_pwm_seq #(
    .NUM_CH(NCH), .CNT_W(CW), .DEL_TICKS(DEL), .GAP_TICKS(GAP),
    .SUP_TICKS(SUP), .SEQ_STEPS(5)
  ) uut (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .stop_i(stop),
    .on_ticks_i(on_t), .period_ticks_i(per_t), .en_o(en), .blank_o(blank)
  );

  // reference model
  int m_act = 0, m_t = 0, m_step = 0, m_on = 0, m_per = 0, m_sp = 0;
  int bcnt[NCH];
  bit last_en[NCH];

  function automatic int ref_space(int s, int on_v, int per_v);
    int sp, lim;
    sp  = DEL + ((on_v + GAP - DEL) * s) / 4;
    lim = (per_v >= on_v) ? (per_v - on_v) / (NCH - 1) : 0;
    return (sp > lim) ? lim : sp;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_act = 0; m_t = 0; m_step = 0; m_on = 0; m_per = 0; m_sp = 0;
    end else if (stop) begin
      m_act = 0; m_t = 0; m_step = 0;
    end else if (start) begin
      m_act = 1; m_t = 0; m_step = 0;
      m_on = int'(on_t); m_per = int'(per_t);
      m_sp = ref_space(0, m_on, m_per);
    end else if (m_act != 0) begin
      if (m_t + 1 >= m_per) begin
        m_t = 0;
        m_step = (m_step < 4) ? m_step + 1 : 4;
        m_on = int'(on_t); m_per = int'(per_t);
        m_sp = ref_space(m_step, m_on, m_per);
      end else m_t++;
    end
  end

  initial for (int k = 0; k < NCH; k++) begin bcnt[k] = 0; last_en[k] = 0; end

  always @(negedge clk) begin
    if (rst_n) begin
      for (int k = 0; k < NCH; k++) begin
        bit ee, eb;
        ee = (m_act != 0) && (m_t >= k * m_sp) && (m_t < k * m_sp + m_on);
        if (ee != last_en[k]) bcnt[k] = SUP;
        last_en[k] = ee;
        eb = bcnt[k] > 0;
        checks++;
        if (en[k] !== ee) begin
          errors++;
          $display("FAIL %s en[%0d] t=%0d step=%0d actual=%b expected=%b",
                   req, k, m_t, m_step + 1, en[k], ee);
        end
        checks++;
        if (blank[k] !== eb) begin
          errors++;
          $display("FAIL R8 blank[%0d] actual=%b expected=%b", k, blank[k], eb);
        end
        if (bcnt[k] > 0) bcnt[k]--;
      end
    end else begin
      checks++;
      if (en !== '0 || blank !== '0) begin
        errors++;
        $display("FAIL R1 reset outputs actual=%b/%b expected=0/0", en, blank);
      end
    end
  end

  task automatic go(int o, int p);
    @(negedge clk);
    on_t = CW'(o); per_t = CW'(p); start = 1'b1;
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic halt();
    @(negedge clk); stop = 1'b1;
    @(negedge clk); stop = 1'b0;
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    req = "R1"; idle(10);
    // shrinking spacing 20,19,17,15,13
    req = "R4"; go(10, 100); idle(700);
    halt(); req = "R7"; idle(20);
    // growing spacing 20,23,26,29,33
    req = "R5"; go(30, 400); idle(2600);
    // clamp: (100-30)/3 = 23
    req = "R6"; go(30, 100); idle(600);
    // on > period: spacing 0
    go(50, 40); idle(200);
    // mid-run change: latched only at period end
    req = "R9"; go(12, 120); idle(50);
    on_t = 25; per_t = 150; idle(500);
    // restart while running
    req = "R10"; idle(7); go(8, 60); idle(300);
    // stop during on-phase, then stop beats start
    req = "R7"; idle(3); halt(); idle(30);
    @(negedge clk); start = 1'b1; stop = 1'b1; on_t = 10; per_t = 80;
    @(negedge clk); start = 1'b0; stop = 1'b0;
    idle(30);
    req = "R3"; go(10, 80); idle(30);
    req = "R2"; idle(400);
    halt(); req = "R7"; idle(40);
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog run did not end");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule